// File: doc/BRIEF.md
# Key-protected DRAM controller register bank

This block holds the 32-bit configuration and status words of a DRAM controller behind a protection-key register. After reset the bank is soft-locked. Software opens it by writing a magic key into the protection word at byte offset 0x00. A second magic value freezes it until the next reset. A short list of scratch and test words is writable in every lock state.

The bank applies fix-ups when it stores a word. The configuration word at 0x04 keeps a fixed version, aperture and reserved pattern, and it takes its RAM-size index from a strap input. The PHY status word at 0x60 always reports idle with the PLL locked. The ECC test control word at 0x70 always reports a finished test that passed. Access is one 32-bit word at a time through a simple strobe port. Reads return registered data one cycle later.

The block drives a 2-bit lock-state output. It also raises a one-cycle pulse when the lock turns away a write, so the surrounding logic can see the refusal.

Top module: `dram_cfg_regbank`

## Requirements
- R1: A write of 0xFC600309 to the protection word (byte offset 0x00) opens the bank. The word then reads 0x01 and `lock_state` is 2'b01. A write of 0xDEADDEAD hard-locks the bank: the word reads 0x10 and `lock_state` is 2'b10. Any other value soft-locks the bank: the word reads 0x00 and `lock_state` is 2'b00. The encoding 2'b11 never appears.
- R2: While hard-locked, every write to a protected word is dropped, and that includes the protection word. Each dropped write raises `wr_blocked`. Only reset leaves this state.
- R3: While soft-locked, writes to protected words other than the protection word are dropped and raise `wr_blocked`. The protection word can still be written, so the key can reopen the bank.
- R4: The words at byte offsets 0x50, 0x6C, 0x74, 0x78, 0x7C, 0x88, 0x8C and 0xB4 store the written data unchanged in every lock state. They never raise `wr_blocked`.
- R5: An accepted write to the configuration word (0x04) stores the written data with these bits forced: bits 31:28 are 4'h3, bits 18:14 are 0, bit 6 is 0, bits 3:2 are 2'b11, and bits 1:0 are `ram_size_idx`.
- R6: `ram_size_idx` codes 0, 1, 2 and 3 stand for 256 MiB, 512 MiB, 1 GiB and 2 GiB. The configuration word takes the strap value present at reset and at each accepted write to that word.
- R7: An accepted write to the PHY status word (0x60) stores the data with bit 0 cleared and bit 4 set.
- R8: An accepted write to the ECC test control word (0x70) stores the data with bit 12 set and bit 13 cleared.
- R9: Reset clears every word and soft-locks the bank. It then loads these values: the configuration word is 0x3000000C with `ram_size_idx` in bits 1:0, byte offset 0x400 holds 0x00000002, offset 0x450 holds 0x0FFFFFFF, and offsets 0x468 and 0x47C hold 0x000000FF.
- R10: The window spans WORDS words (byte offsets 0x000 up to 4*WORDS-1). A read outside it returns 0. A write outside it changes nothing and does not raise `wr_blocked`. An outside address never aliases a word inside the window.
- R11: `rdata` is updated on the clock edge that samples `rd_en` and holds its value until the next read. A write takes effect on the edge that samples `wr_en`. `wr_blocked` is high for exactly the cycle after a refused write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word |
| rd_en | input | 1 | Read strobe, one word |
| addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| wdata | input | 32 | Write data |
| ram_size_idx | input | 2 | RAM-size strap index |
| rdata | output | 32 | Registered read data |
| lock_state | output | 2 | 00 soft-locked, 01 open, 10 hard-locked |
| wr_blocked | output | 1 | One-cycle pulse after a write refused by the lock |

## Verification
The assertions check the lock rules on every cycle:
- The hard lock never leaves its state.
- The soft lock changes only after a protection-word write.
- Every refused write produces a pulse, and every pulse follows a refused write.
- Bypass and out-of-window writes never pulse.
- Read data holds between reads.
- Configuration reads show the fixed fields.

Only the bench scenarios can show what is stored. They compare read-back values against a reference model under random traffic. This covers the fix-ups on the status words, the strap value following into the configuration word, the bypass words keeping their data under lock, the absence of aliasing outside the window, and the reset image being restored after a hard lock.

// File: rtl/dcr_pkg.sv
// Package: shared types, keys, word indices and the fix-up functions of the
// key-protected DRAM controller register bank.
// Assumes 32-bit words addressed by byte address with bits 1:0 ignored.
package dcr_pkg;

    localparam int DW = 32;

    // Lock state; the value doubles as the lock_state output encoding.
    typedef enum logic [1:0] {
        LK_SOFT = 2'b00,
        LK_OPEN = 2'b01,
        LK_HARD = 2'b10
    } lock_e;

    // Class of a word, selecting the write fix-up.
    typedef enum logic [2:0] {
        RC_PLAIN,
        RC_PROT,
        RC_CONF,
        RC_PHYSTAT,
        RC_ECCTEST
    } rclass_e;

    localparam logic [DW-1:0] KEY_OPEN = 32'hFC60_0309;
    localparam logic [DW-1:0] KEY_HARD = 32'hDEAD_DEAD;
    localparam logic [DW-1:0] PROT_RD_OPEN = 32'h0000_0001;
    localparam logic [DW-1:0] PROT_RD_HARD = 32'h0000_0010;

    // Word indices (byte offset / 4).
    localparam int unsigned WI_PROT    = 0;
    localparam int unsigned WI_CONF    = 1;
    localparam int unsigned WI_PHYSTAT = 24;
    localparam int unsigned WI_ECCTEST = 28;
    localparam int unsigned WI_PHYOK   = 256;
    localparam int unsigned WI_EYE_W   = 276;
    localparam int unsigned WI_EYE_A   = 282;
    localparam int unsigned WI_EYE_B   = 287;

    // Words that ignore the lock.
    localparam int N_BYPASS = 8;
    localparam int unsigned BYPASS_IDX [N_BYPASS] = '{20, 27, 29, 30, 31, 34, 35, 45};

    // Configuration word: bits held fixed, and the value of the non-strap ones.
    localparam logic [DW-1:0] CONF_HELD_MASK  = 32'hF007_C04F;
    localparam logic [DW-1:0] CONF_HELD_VALUE = 32'h3000_000C;

    localparam logic [DW-1:0] PHY_BUSY_BIT   = 32'h0000_0001;
    localparam logic [DW-1:0] PHY_PLL_BIT    = 32'h0000_0010;
    localparam logic [DW-1:0] ECC_DONE_BIT   = 32'h0000_1000;
    localparam logic [DW-1:0] ECC_FAILED_BIT = 32'h0000_2000;

    // Builds a configuration word from written data and the strap index.
    function automatic logic [DW-1:0] conf_word(logic [DW-1:0] d, logic [1:0] idx);
        return (d & ~CONF_HELD_MASK) | CONF_HELD_VALUE | {30'd0, idx};
    endfunction

    // Reset image of one word.
    function automatic logic [DW-1:0] reset_word(int unsigned w, logic [1:0] idx);
        logic [DW-1:0] v;
        v = '0;
        if (w == WI_CONF)  v = conf_word('0, idx);
        if (w == WI_PHYOK) v = 32'h0000_0002;
        if (w == WI_EYE_W) v = 32'h0FFF_FFFF;
        if (w == WI_EYE_A || w == WI_EYE_B) v = 32'h0000_00FF;
        return v;
    endfunction

endpackage

// File: rtl/dcr_addr_decode.sv
// Address decoder: turns a byte address into a window hit, a word index,
// a lock-bypass flag and a word class.
// Assumes ADDR_W-2 bits of word address cover at least WORDS words.
module dcr_addr_decode
    import dcr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORDS  = 512
) (
    input  logic [ADDR_W-1:0]         addr,
    output logic                      in_win,
    output logic [$clog2(WORDS)-1:0]  widx,
    output logic                      bypass,
    output rclass_e                   cls
);
    localparam int WA     = ADDR_W - 2;
    localparam int WIDX_W = $clog2(WORDS);

    logic [WA-1:0]       word_full;
    logic [31:0]         word_ext;
    logic [N_BYPASS-1:0] hit;

    assign word_full = addr[ADDR_W-1:2];
    assign word_ext  = 32'(word_full);
    assign widx      = word_full[WIDX_W-1:0];

    // Window hit: the full word address is below the bank depth.
    assign in_win = (word_ext < 32'(WORDS));

    // One comparator per bypass word.
    for (genvar g = 0; g < N_BYPASS; g++) begin : g_byp
        assign hit[g] = (word_ext == BYPASS_IDX[g]);
    end
    assign bypass = |hit;

    // Class select for the write fix-up.
    always_comb begin
        cls = RC_PLAIN;
        if (word_ext == WI_PROT)         cls = RC_PROT;
        else if (word_ext == WI_CONF)    cls = RC_CONF;
        else if (word_ext == WI_PHYSTAT) cls = RC_PHYSTAT;
        else if (word_ext == WI_ECCTEST) cls = RC_ECCTEST;
    end

endmodule

// File: rtl/dcr_lock_fsm.sv
// Lock state machine: soft-locked after reset, opened by the open key,
// frozen by the hard key. prot_wr must be asserted only for an accepted
// protection-word write; the caller refuses such writes when hard-locked.
module dcr_lock_fsm
    import dcr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prot_wr,
    input  logic [DW-1:0] wdata,
    output lock_e         state
);
    // Key decode on every accepted protection-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LK_SOFT;
        end else if (prot_wr) begin
            if (wdata == KEY_OPEN)      state <= LK_OPEN;
            else if (wdata == KEY_HARD) state <= LK_HARD;
            else                        state <= LK_SOFT;
        end
    end
endmodule

// File: rtl/dcr_write_fixup.sv
// Write fix-up: forms the stored value of an accepted write from its class.
// Purely combinational; protection-word data is not stored here.
module dcr_write_fixup
    import dcr_pkg::*;
(
    input  rclass_e       cls,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    size_idx,
    output logic [DW-1:0] wfix
);
    // Per-class forcing of read-only and status bits.
    always_comb begin
        unique case (cls)
            RC_CONF:    wfix = conf_word(wdata, size_idx);
            RC_PHYSTAT: wfix = (wdata & ~PHY_BUSY_BIT) | PHY_PLL_BIT;
            RC_ECCTEST: wfix = (wdata | ECC_DONE_BIT) & ~ECC_FAILED_BIT;
            default:    wfix = wdata;
        endcase
    end
endmodule

// File: rtl/dram_cfg_regbank.sv
// Top: key-protected DRAM controller register bank. It decodes the address,
// gates writes by the lock state and the bypass list, stores the fixed-up
// words, returns registered read data and pulses on refused writes.
// Assumes single-word accesses; a read and a write in the same cycle are
// both served, and the read returns the value from before the edge.
module dram_cfg_regbank
    import dcr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORDS  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [1:0]        ram_size_idx,
    output logic [31:0]       rdata,
    output logic [1:0]        lock_state,
    output logic              wr_blocked
);
    localparam int WIDX_W = $clog2(WORDS);

    logic              dec_in_win;
    logic [WIDX_W-1:0] dec_widx;
    logic              dec_bypass;
    rclass_e           dec_cls;
    lock_e             lock_q;
    logic              prot_wr;
    logic              wr_store;
    logic              wr_reject;
    logic [DW-1:0]     wfix;
    logic [DW-1:0]     store_data;
    logic [DW-1:0]     prot_rd;
    logic [DW-1:0]     bank [WORDS];

    dcr_addr_decode #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_dec (
        .addr   (addr),
        .in_win (dec_in_win),
        .widx   (dec_widx),
        .bypass (dec_bypass),
        .cls    (dec_cls)
    );

    dcr_lock_fsm u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .prot_wr (prot_wr),
        .wdata   (wdata),
        .state   (lock_q)
    );

    dcr_write_fixup u_fix (
        .cls      (dec_cls),
        .wdata    (wdata),
        .size_idx (ram_size_idx),
        .wfix     (wfix)
    );

    // Write gate: bypass words first, then the hard lock, then the protection word, then the soft lock.
    always_comb begin
        wr_store  = 1'b0;
        prot_wr   = 1'b0;
        wr_reject = 1'b0;
        if (wr_en && dec_in_win) begin
            if (dec_bypass)                wr_store  = 1'b1;
            else if (lock_q == LK_HARD)    wr_reject = 1'b1;
            else if (dec_cls == RC_PROT)   prot_wr   = 1'b1;
            else if (lock_q == LK_SOFT)    wr_reject = 1'b1;
            else                           wr_store  = 1'b1;
        end
    end

    assign store_data = dec_bypass ? wdata : wfix;

    // Word storage: reset image on reset, otherwise the gated write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int unsigned i = 0; i < WORDS; i++) begin
                bank[i] <= reset_word(i, ram_size_idx);
            end
        end else if (wr_store) begin
            bank[dec_widx] <= store_data;
        end
    end

    // Protection-word read value from the lock state.
    always_comb begin
        unique case (lock_q)
            LK_OPEN: prot_rd = PROT_RD_OPEN;
            LK_HARD: prot_rd = PROT_RD_HARD;
            default: prot_rd = '0;
        endcase
    end

    // Registered read port; holds its value between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (!dec_in_win)              rdata <= '0;
            else if (dec_cls == RC_PROT)  rdata <= prot_rd;
            else                          rdata <= bank[dec_widx];
        end
    end

    // One-cycle pulse after a refused write.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_blocked <= 1'b0;
        else        wr_blocked <= wr_reject;
    end

    assign lock_state = lock_q;

endmodule

// File: rtl/dcr_regbank_chk.sv
// Checker for dram_cfg_regbank: cycle-level properties of the lock, the
// refusal pulse and the read port. Attached by the bind below.
module dcr_regbank_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic [1:0]        lock_state,
    input logic              wr_blocked,
    input logic              dec_in_win,
    input logic              dec_bypass
);
    logic at_prot;
    logic at_conf;
    assign at_prot = dec_in_win && (addr[ADDR_W-1:2] == '0);
    assign at_conf = dec_in_win && (addr[ADDR_W-1:2] == (ADDR_W-2)'(1));

    // R1
    lock_enc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_state != 2'b11);

    // R2
    hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_state == 2'b10 |=> lock_state == 2'b10);

    // R2
    hard_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec_in_win && !dec_bypass && lock_state == 2'b10) |=> wr_blocked);

    // R3
    soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state == 2'b00 && !(wr_en && at_prot)) |=> lock_state == 2'b00);

    // R4
    bypass_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec_bypass) |=> !wr_blocked);

    // R5
    conf_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && at_conf) |=> (rdata[31:28] == 4'h3 && rdata[18:14] == 5'd0
                                && !rdata[6] && rdata[3:2] == 2'b11));

    // R10
    outwin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !dec_in_win) |=> rdata == 32'd0);

    // R10
    outwin_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dec_in_win) |=> !wr_blocked);

    // R11
    blocked_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blocked |-> $past(wr_en && dec_in_win && !dec_bypass));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind dram_cfg_regbank dcr_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .rdata      (rdata),
    .lock_state (lock_state),
    .wr_blocked (wr_blocked),
    .dec_in_win (dec_in_win),
    .dec_bypass (dec_bypass)
);

// File: tb/sim_dram_cfg_regbank.sv
`timescale 1ns/1ps
// Bench: reference model of the register bank with directed corner cases
// and seeded random traffic; every write checks the refusal pulse and the
// lock state, and every read checks the data.
module sim_dram_cfg_regbank;
    localparam int AW = 12;
    localparam int NW = 512;
    localparam logic [31:0] K_OPEN = 32'hFC60_0309;
    localparam logic [31:0] K_HARD = 32'hDEAD_DEAD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [1:0]    ram_size_idx = 2'd1;
    logic [31:0]   rdata;
    logic [1:0]    lock_state;
    logic          wr_blocked;

    always #2.5 clk = ~clk;

    dram_cfg_regbank #(.ADDR_W(AW), .WORDS(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .ram_size_idx(ram_size_idx), .rdata(rdata),
        .lock_state(lock_state), .wr_blocked(wr_blocked)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] m_reg [NW];
    logic [1:0]  m_lock;

    function automatic bit is_bypass(int w);
        return w inside {20, 27, 29, 30, 31, 34, 35, 45};
    endfunction

    // Expected stored value of an accepted write (R5, R6, R7, R8).
    function automatic logic [31:0] fix(int w, logic [31:0] d, logic [1:0] idx);
        case (w)
            1:  return (d & 32'h0FF8_3FB0) | 32'h3000_000C | {30'd0, idx};
            24: return (d & 32'hFFFF_FFFE) | 32'h0000_0010;
            28: return (d | 32'h0000_1000) & 32'hFFFF_DFFF;
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
        int w;
        if (a >= 12'h800) return 32'd0;
        w = int'(a[10:2]);
        if (w == 0) return (m_lock == 2'b01) ? 32'h1 : (m_lock == 2'b10) ? 32'h10 : 32'h0;
        return m_reg[w];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NW; i++) m_reg[i] = 32'd0;
        m_reg[1]   = 32'h3000_000C | {30'd0, ram_size_idx};
        m_reg[256] = 32'h0000_0002;
        m_reg[276] = 32'h0FFF_FFFF;
        m_reg[282] = 32'h0000_00FF;
        m_reg[287] = 32'h0000_00FF;
        m_lock = 2'b00;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    // Write one word; the model predicts the refusal pulse and the lock.
    task automatic wr(logic [AW-1:0] a, logic [31:0] d, string req);
        bit blk;
        int w;
        blk = 1'b0;
        if (a < 12'h800) begin
            w = int'(a[10:2]);
            if (is_bypass(w)) m_reg[w] = d;
            else if (m_lock == 2'b10) blk = 1'b1;
            else if (w == 0) m_lock = (d == K_OPEN) ? 2'b01 : (d == K_HARD) ? 2'b10 : 2'b00;
            else if (m_lock == 2'b00) blk = 1'b1;
            else m_reg[w] = fix(w, d, ram_size_idx);
        end
        @(negedge clk);
        wr_en = 1'b1;
        addr = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        check({req, " wr_blocked"}, {31'd0, wr_blocked}, {31'd0, blk});
        check({req, " lock_state"}, {30'd0, lock_state}, {30'd0, m_lock});
    endtask

    task automatic rd(logic [AW-1:0] a, string req);
        logic [31:0] e;
        e = exp_rd(a);
        @(negedge clk);
        rd_en = 1'b1;
        addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check({req, " rdata"}, rdata, e);
    endtask

    function automatic logic [AW-1:0] pick_addr();
        int s;
        s = $urandom_range(0, 9);
        case (s)
            0: return 12'h000;
            1: return 12'h004;
            2: return 12'h060;
            3: return 12'h070;
            4: begin
                int b;
                b = $urandom_range(0, 7);
                case (b)
                    0: return 12'h050; 1: return 12'h06C; 2: return 12'h074; 3: return 12'h078;
                    4: return 12'h07C; 5: return 12'h088; 6: return 12'h08C; default: return 12'h0B4;
                endcase
            end
            5, 6: return AW'($urandom_range(0, 63) * 4);
            7: return AW'($urandom_range(0, NW - 1) * 4);
            8: return 12'h800 | AW'($urandom & 32'h7FC);
            default: return 12'h008;
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        do_reset();
        @(negedge clk);
        // R9 R1: reset image and soft lock
        check("R1 reset lock", {30'd0, lock_state}, 32'd0);
        check("R11 reset pulse", {31'd0, wr_blocked}, 32'd0);
        rd(12'h000, "R1 reset prot");
        rd(12'h004, "R9 R6 reset conf");
        rd(12'h400, "R9 phy ok");
        rd(12'h450, "R9 eye 450");
        rd(12'h468, "R9 eye 468");
        rd(12'h47C, "R9 eye 47C");
        rd(12'h008, "R9 plain zero");
        // R3: soft-locked refuses a protected word; R4: bypass still writes
        wr(12'h008, 32'hA5A5_0001, "R3 soft refuse");
        rd(12'h008, "R3 soft unchanged");
        wr(12'h050, 32'h1234_5678, "R4 bypass soft");
        rd(12'h050, "R4 bypass soft read");
        // R1: open
        wr(12'h000, K_OPEN, "R1 open");
        rd(12'h000, "R1 open read");
        // R5: all ones and all zeros into the configuration word
        wr(12'h004, 32'hFFFF_FFFF, "R5 conf ones");
        rd(12'h004, "R5 conf ones read");
        ram_size_idx = 2'd3;
        wr(12'h004, 32'h0000_0000, "R6 conf strap");
        rd(12'h004, "R6 conf strap read");
        // R7 and R8
        wr(12'h060, 32'h0000_0001, "R7 phy busy");
        rd(12'h060, "R7 phy read");
        wr(12'h060, 32'hFFFF_FFFF, "R7 phy ones");
        rd(12'h060, "R7 phy ones read");
        wr(12'h070, 32'h0000_2000, "R8 ecc fail");
        rd(12'h070, "R8 ecc read");
        // R10: outside the window, no alias onto word 1
        wr(12'hC04, 32'h0BAD_0BAD, "R10 outside write");
        rd(12'h004, "R10 no alias");
        rd(12'h800, "R10 outside read");
        rd(12'hFFC, "R10 outside top");
        // R11: read data holds while a later write changes the word
        rd(12'h008, "R11 read");
        wr(12'h008, 32'hCAFE_F00D, "R11 write");
        check("R11 hold", rdata, 32'd0);
        rd(12'h008, "R11 new value");
        // R1 R3: other value soft-locks, key reopens
        wr(12'h000, 32'h1234_5678, "R1 soft relock");
        wr(12'h00C, 32'h1, "R3 refuse again");
        wr(12'h000, K_OPEN, "R3 reopen");
        // Random traffic without the hard key
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] a;
            logic [31:0] d;
            a = pick_addr();
            d = $urandom;
            if (a == 12'h000 && $urandom_range(0, 9) < 6) d = K_OPEN;
            if ($urandom_range(0, 49) == 0) ram_size_idx = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 0) wr(a, d, "R1-random write");
            else rd(a, "R5-random read");
        end
        // R2: hard lock
        wr(12'h000, K_OPEN, "R2 open first");
        wr(12'h000, K_HARD, "R2 hard");
        rd(12'h000, "R2 hard read");
        wr(12'h000, K_OPEN, "R2 key refused");
        wr(12'h004, 32'h0, "R2 conf refused");
        rd(12'h004, "R2 conf kept");
        wr(12'h08C, 32'h7777_8888, "R4 bypass hard");
        rd(12'h08C, "R4 bypass hard read");
        // R9: reset leaves the hard lock and restores the image
        ram_size_idx = 2'd2;
        do_reset();
        @(negedge clk);
        check("R9 lock after reset", {30'd0, lock_state}, 32'd0);
        rd(12'h08C, "R9 bypass cleared");
        rd(12'h004, "R9 conf strap 2");
        wr(12'h000, K_OPEN, "R9 open after reset");
        wr(12'h010, 32'h55AA_55AA, "R9 write after reset");
        rd(12'h010, "R9 read after reset");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule